// File: doc/BRIEF.md
# Indirect PHY Register Access Bridge

This block sits on a 16-bit host register bus and lets the host reach the internal registers of a small set of embedded PHYs without a dedicated address range per PHY. The host first writes a direction flag into a control register, choosing a read or a write. It then issues one bus write to a window address. The window address carries the target itself: a one-hot PHY select, a page number and a register number. That single write launches one transaction on a plain request/acknowledge interface towards the PHYs.

For a PHY write, the bus data of the window access is the value sent. For a PHY read, the bus data is discarded, and the value the PHY returns is captured into a data register that the host fetches later. While a transaction is outstanding, the bridge reports busy and drops further window writes. A window address that names no legal PHY or page is refused and leaves a sticky error flag behind.

Top module: `phy_ind_bridge`

## Requirements
- R1: After reset no PHY request is pending, and host reads of the control register (0x8000) and the data register (0x8002) both return 0.
- R2: A host write to 0x8000 latches bit 0 as the direction: 1 means read and 0 means write. A read of 0x8000 returns the direction in bit 0, busy in bit 1 and the sticky error in bit 2, with all other bits 0.
- R3: A window address has bit 15 set and a nonzero PHY select in bits 14:9, where bit 9+n selects PHY n. Bits 8:5 hold the page and bits 4:0 the register. A legal window write while idle raises phy_req_o on the next clock edge, with phy_idx_o, phy_page_o and phy_reg_o decoded from the address.
- R4: When the latched direction is write, the request has phy_we_o=1 and phy_wdata_o equal to the bus write data of the window access.
- R5: When the latched direction is read, the request has phy_we_o=0 and phy_wdata_o=0, whatever the bus write data was.
- R6: Once raised, phy_req_o and all request fields stay constant until the clock edge at which phy_ack_i is high. The busy bit is set over the same span, and the request drops at that edge.
- R7: A window write that arrives while busy is dropped: the pending fields do not change and no further request follows. This also holds when the window write falls in the same cycle as the ack.
- R8: For a read request, phy_rdata_i is captured at the ack edge and 0x8002 returns that value. The value stays until the next read completes. Write completions and acks that arrive with no request pending leave it unchanged.
- R9: A window write whose PHY select is not one-hot, selects a PHY index of 5 or more, or whose page field is 8 or more starts no request and sets the sticky error bit.
- R10: A write to 0x8000 with bit 2 set clears the error bit. The same write also latches the direction from bit 0.
- R11: Changing the direction while a request is pending does not alter phy_we_o or phy_wdata_o of that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_valid_i | input | 1 | Host access valid this cycle |
| bus_write_i | input | 1 | Host access is a write |
| bus_addr_i | input | 16 | Host word address |
| bus_wdata_i | input | DATA_W | Host write data |
| bus_rdata_o | output | DATA_W | Host read data, same cycle |
| phy_req_o | output | 1 | PHY request pending |
| phy_idx_o | output | IDX_W | Target PHY index |
| phy_page_o | output | PAGE_W | Target page |
| phy_reg_o | output | 5 | Target register |
| phy_we_o | output | 1 | 1 for write, 0 for read |
| phy_wdata_o | output | DATA_W | Value to write |
| phy_ack_i | input | 1 | PHY completes the request |
| phy_rdata_i | input | DATA_W | PHY read value, valid with ack |

## Verification
The functions that can share a cycle are the completion of a pending request and a new window trigger. The bench raises phy_ack_i in the same cycle as a window write to another PHY. It then expects the request to drop and stay low, because the trigger was seen while busy. A second overlap is a direction change while a read is pending. The bench judges that one by phy_we_o staying 0 and by the acked value still landing in the data register.

// File: rtl/phy_bridge_pkg.sv
package phy_bridge_pkg;
  localparam int unsigned  BUS_AW    = 16;
  localparam logic [15:0]  CTRL_ADDR = 16'h8000;
  localparam logic [15:0]  DATA_ADDR = 16'h8002;
  localparam int unsigned  WIN_BIT   = 15;
  localparam int unsigned  SEL_LSB   = 9;
  localparam int unsigned  SEL_W     = 6;
  localparam int unsigned  PG_LSB    = 5;
  localparam int unsigned  PG_FW     = 4;
  localparam int unsigned  REG_W     = 5;
  localparam int unsigned  DIR_BIT   = 0;
  localparam int unsigned  BUSY_BIT  = 1;
  localparam int unsigned  ERR_BIT   = 2;

  typedef enum logic {ST_IDLE, ST_WAIT} seq_st_e;
endpackage

// File: rtl/phy_win_decode.sv
module phy_win_decode
  import phy_bridge_pkg::*;
#(
  parameter int unsigned NUM_PHY  = 5,
  parameter int unsigned NUM_PAGE = 8,
  parameter int unsigned IDX_W    = 3,
  parameter int unsigned PAGE_W   = 3
) (
  input  logic [BUS_AW-1:0] addr_i,
  output logic              hit_o,
  output logic              ok_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [PAGE_W-1:0] page_o,
  output logic [REG_W-1:0]  reg_o
);
  localparam int unsigned POS_W = $clog2(SEL_W);
  localparam logic [POS_W:0] PHY_LIM  = (POS_W+1)'(NUM_PHY);
  localparam logic [PG_FW:0] PAGE_LIM = (PG_FW+1)'(NUM_PAGE);

  logic [SEL_W-1:0] sel;
  logic [PG_FW-1:0] pfield;
  logic [POS_W:0]   cnt;
  logic [POS_W-1:0] pos;

  always_comb begin
    sel    = addr_i[SEL_LSB +: SEL_W];
    pfield = addr_i[PG_LSB +: PG_FW];
    cnt    = '0;
    pos    = '0;
    for (int i = 0; i < SEL_W; i++) begin
      if (sel[i]) begin
        cnt = cnt + 1'b1;
        pos = POS_W'(i);
      end
    end
    hit_o  = addr_i[WIN_BIT] && (sel != '0);
    ok_o   = hit_o && (cnt == 1) && ({1'b0, pos} < PHY_LIM) &&
             ({1'b0, pfield} < PAGE_LIM);
    idx_o  = IDX_W'(pos);
    page_o = PAGE_W'(pfield);
    reg_o  = addr_i[REG_W-1:0];
  end
endmodule

// File: rtl/phy_req_seq.sv
module phy_req_seq
  import phy_bridge_pkg::*;
#(
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned PAGE_W = 3,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rd_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [REG_W-1:0]  reg_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ack_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              req_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [PAGE_W-1:0] page_o,
  output logic [REG_W-1:0]  reg_o,
  output logic              we_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] rd_data_o
);
  seq_st_e           st_q;
  logic [IDX_W-1:0]  idx_q;
  logic [PAGE_W-1:0] page_q;
  logic [REG_W-1:0]  reg_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      page_q  <= '0;
      reg_q   <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      rd_q    <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            st_q    <= ST_WAIT;
            idx_q   <= idx_i;
            page_q  <= page_i;
            reg_q   <= reg_i;
            we_q    <= !rd_i;
            wdata_q <= rd_i ? '0 : wdata_i;
          end
        end
        ST_WAIT: begin
          if (ack_i) begin
            st_q <= ST_IDLE;
            if (!we_q) rd_q <= rdata_i;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_o     = (st_q == ST_WAIT);
  assign idx_o     = idx_q;
  assign page_o    = page_q;
  assign reg_o     = reg_q;
  assign we_o      = we_q;
  assign wdata_o   = wdata_q;
  assign rd_data_o = rd_q;

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i |=> req_o && $stable(idx_o) && $stable(page_o) &&
    $stable(reg_o) && $stable(we_o) && $stable(wdata_o));

  p_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && ack_i |=> !req_o);

  p_capture_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && ack_i && !we_o |=> rd_data_o == $past(rdata_i));

  p_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_o && ack_i && !we_o) |=> $stable(rd_data_o));

  p_rd_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !we_o |-> wdata_o == '0);
endmodule

// File: rtl/phy_ind_bridge.sv
module phy_ind_bridge
  import phy_bridge_pkg::*;
#(
  parameter  int unsigned NUM_PHY  = 5,
  parameter  int unsigned NUM_PAGE = 8,
  parameter  int unsigned DATA_W   = 16,
  localparam int unsigned IDX_W    = (NUM_PHY  > 1) ? $clog2(NUM_PHY)  : 1,
  localparam int unsigned PAGE_W   = (NUM_PAGE > 1) ? $clog2(NUM_PAGE) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              phy_req_o,
  output logic [IDX_W-1:0]  phy_idx_o,
  output logic [PAGE_W-1:0] phy_page_o,
  output logic [REG_W-1:0]  phy_reg_o,
  output logic              phy_we_o,
  output logic [DATA_W-1:0] phy_wdata_o,
  input  logic              phy_ack_i,
  input  logic [DATA_W-1:0] phy_rdata_i
);
  logic              win_hit, win_ok;
  logic [IDX_W-1:0]  dec_idx;
  logic [PAGE_W-1:0] dec_page;
  logic [REG_W-1:0]  dec_reg;
  logic              bus_wr, ctrl_wr, win_wr, start;
  logic              dir_rd_q, err_q;
  logic [DATA_W-1:0] rd_data;

  phy_win_decode #(
    .NUM_PHY (NUM_PHY),
    .NUM_PAGE(NUM_PAGE),
    .IDX_W   (IDX_W),
    .PAGE_W  (PAGE_W)
  ) u_dec (
    .addr_i(bus_addr_i),
    .hit_o (win_hit),
    .ok_o  (win_ok),
    .idx_o (dec_idx),
    .page_o(dec_page),
    .reg_o (dec_reg)
  );

  assign bus_wr  = bus_valid_i && bus_write_i;
  assign ctrl_wr = bus_wr && (bus_addr_i == CTRL_ADDR);
  assign win_wr  = bus_wr && win_hit;
  assign start   = win_wr && win_ok && !phy_req_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_rd_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (ctrl_wr) dir_rd_q <= bus_wdata_i[DIR_BIT];
      if (win_wr && !win_ok)                  err_q <= 1'b1;
      else if (ctrl_wr && bus_wdata_i[ERR_BIT]) err_q <= 1'b0;
    end
  end

  phy_req_seq #(
    .IDX_W (IDX_W),
    .PAGE_W(PAGE_W),
    .DATA_W(DATA_W)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .rd_i     (dir_rd_q),
    .idx_i    (dec_idx),
    .page_i   (dec_page),
    .reg_i    (dec_reg),
    .wdata_i  (bus_wdata_i),
    .ack_i    (phy_ack_i),
    .rdata_i  (phy_rdata_i),
    .req_o    (phy_req_o),
    .idx_o    (phy_idx_o),
    .page_o   (phy_page_o),
    .reg_o    (phy_reg_o),
    .we_o     (phy_we_o),
    .wdata_o  (phy_wdata_o),
    .rd_data_o(rd_data)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (bus_valid_i && !bus_write_i) begin
      if (bus_addr_i == CTRL_ADDR) begin
        bus_rdata_o[DIR_BIT]  = dir_rd_q;
        bus_rdata_o[BUSY_BIT] = phy_req_o;
        bus_rdata_o[ERR_BIT]  = err_q;
      end else if (bus_addr_i == DATA_ADDR) begin
        bus_rdata_o = rd_data;
      end
    end
  end

  p_bad_err_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_wr && !win_ok |=> err_q);

  p_bad_noreq_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_wr && !win_ok && !phy_req_o |=> !phy_req_o);

  p_busy_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_req_o && !phy_ack_i && win_wr |=> $stable(phy_idx_o) &&
    $stable(phy_reg_o) && $stable(phy_page_o));

  p_dir_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_req_o && !phy_ack_i && ctrl_wr |=> $stable(phy_we_o));

  p_idx_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_req_o |-> ({1'b0, phy_idx_o} < (IDX_W+1)'(NUM_PHY)));

  p_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_wr && win_ok && !phy_req_o |=> phy_req_o);
endmodule

// File: tb/phy_ind_bridge_tb.sv
module phy_ind_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [15:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
  logic        phy_req, phy_we;
  logic [2:0]  phy_idx, phy_page;
  logic [4:0]  phy_reg;
  logic [15:0] phy_wdata;
  logic        phy_ack = 1'b0;
  logic [15:0] phy_rdata = '0;
  int total = 0, bad = 0;
  bit done = 1'b0;

  localparam logic [15:0] CTRL = 16'h8000, DATA = 16'h8002;

  always #5 clk = ~clk;

  phy_ind_bridge dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_valid_i(bus_valid), .bus_write_i(bus_write),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .phy_req_o(phy_req), .phy_idx_o(phy_idx), .phy_page_o(phy_page),
    .phy_reg_o(phy_reg), .phy_we_o(phy_we), .phy_wdata_o(phy_wdata),
    .phy_ack_i(phy_ack), .phy_rdata_i(phy_rdata)
  );

  function automatic logic [15:0] win(input int phy, input int page, input int rg);
    return 16'h8000 | 16'(1 << (phy + 9)) | (16'(page << 5) & 16'h01E0) | (16'(rg) & 16'h001F);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] v);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 v = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic ack(input logic [15:0] v);
    @(negedge clk);
    phy_ack = 1'b1; phy_rdata = v;
    @(negedge clk);
    phy_ack = 1'b0; phy_rdata = '0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    check("R1 req", phy_req, 0);
    rd(CTRL, v); check("R1 ctrl", v, 0);
    rd(DATA, v); check("R1 data", v, 0);
  endtask

  task automatic t_write_op();
    logic [15:0] v;
    wr(CTRL, 16'h0000);
    wr(win(2, 3, 17), 16'hA5A5);
    check("R3 req", phy_req, 1);
    check("R3 idx", phy_idx, 2);
    check("R3 page", phy_page, 3);
    check("R3 reg", phy_reg, 17);
    check("R4 we", phy_we, 1);
    check("R4 wdata", phy_wdata, 16'hA5A5);
    rd(CTRL, v); check("R6 busy", v, 2);
    repeat (3) @(negedge clk);
    check("R6 held", phy_req, 1);
    check("R6 wdata stable", phy_wdata, 16'hA5A5);
    ack(16'h7777);
    check("R6 drop", phy_req, 0);
    rd(DATA, v); check("R8 write keeps data", v, 0);
  endtask

  task automatic t_read_op();
    logic [15:0] v;
    wr(CTRL, 16'h0001);
    rd(CTRL, v); check("R2 dir", v, 1);
    wr(win(4, 7, 31), 16'hFFFF);
    check("R3 req", phy_req, 1);
    check("R3 idx", phy_idx, 4);
    check("R3 page", phy_page, 7);
    check("R3 reg", phy_reg, 31);
    check("R5 we", phy_we, 0);
    check("R5 wdata", phy_wdata, 0);
    ack(16'h1234);
    rd(DATA, v); check("R8 capture", v, 16'h1234);
    rd(CTRL, v); check("R2 idle ctrl", v, 1);
  endtask

  task automatic t_busy_drop();
    logic [15:0] v;
    wr(CTRL, 16'h0001);
    wr(win(0, 0, 1), 16'h0000);
    wr(win(1, 2, 3), 16'h5555);
    check("R7 idx kept", phy_idx, 0);
    check("R7 page kept", phy_page, 0);
    check("R7 reg kept", phy_reg, 1);
    wr(CTRL, 16'h0000);
    check("R11 we kept", phy_we, 0);
    check("R11 wdata kept", phy_wdata, 0);
    rd(CTRL, v); check("R2 ctrl busy dir0", v, 2);
    ack(16'hBEEF);
    rd(DATA, v); check("R8 busy read data", v, 16'hBEEF);
    check("R7 no queued req", phy_req, 0);
    repeat (2) @(negedge clk);
    check("R7 still idle", phy_req, 0);
  endtask

  task automatic t_collide();
    logic [15:0] v;
    wr(CTRL, 16'h0000);
    wr(win(3, 1, 4), 16'h1111);
    check("R3 req", phy_req, 1);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = win(1, 0, 0); bus_wdata = 16'h2222;
    phy_ack = 1'b1; phy_rdata = 16'h3333;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; phy_ack = 1'b0;
    check("R7 collide dropped", phy_req, 0);
    @(negedge clk);
    check("R7 collide idle", phy_req, 0);
    rd(DATA, v); check("R8 write ack keeps data", v, 16'hBEEF);
  endtask

  task automatic t_invalid();
    logic [15:0] v;
    wr(16'h8000 | 16'h0600 | 16'h0005, 16'h0000);
    check("R9 two-hot no req", phy_req, 0);
    rd(CTRL, v); check("R9 two-hot err", v, 4);
    wr(CTRL, 16'h0004);
    rd(CTRL, v); check("R10 cleared", v, 0);
    wr(16'hC002, 16'h0000);
    check("R9 phy5 no req", phy_req, 0);
    rd(CTRL, v); check("R9 phy5 err", v, 4);
    wr(CTRL, 16'h0005);
    rd(CTRL, v); check("R10 clear and dir", v, 1);
    wr(win(1, 8, 0), 16'h0000);
    check("R9 page8 no req", phy_req, 0);
    rd(CTRL, v); check("R9 page8 err", v, 5);
    wr(CTRL, 16'h0004);
    wr(16'h8004, 16'h0000);
    check("R3 non-window no req", phy_req, 0);
    rd(CTRL, v); check("R9 non-window no err", v, 0);
    rd(DATA, v); check("R8 data after invalid", v, 16'hBEEF);
  endtask

  task automatic t_stray_ack();
    logic [15:0] v;
    ack(16'h9999);
    check("R8 stray ack no req", phy_req, 0);
    rd(DATA, v); check("R8 stray ack data", v, 16'hBEEF);
    wr(CTRL, 16'h0001);
    wr(win(1, 5, 9), 16'h0000);
    check("R3 idx after errors", phy_idx, 1);
    check("R3 page after errors", phy_page, 5);
    ack(16'h0ABC);
    rd(DATA, v); check("R8 new read", v, 16'h0ABC);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_op();
    t_read_op();
    t_busy_drop();
    t_collide();
    t_invalid();
    t_stray_ack();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule